// File: doc/BRIEF.md
# Confidence-Steered Prefetch Filter and Prioritizer

This block sits on the path from a prefetch engine to the memory network. Every cycle it may receive one prefetch candidate made up of a line address, a code-region identifier and a position within the prefetch stream. Each candidate arrives with a confidence class and a warm flag from an external predictor. The block decides whether to drop the candidate, put it in an urgent queue, or put it in a background queue. It then offers the queued requests downstream over a valid/ready port. The urgent queue always goes first.

The decision depends only on the confidence of that one request and on whether its stream position has finished training. It does not depend on how full the queues are or on any global accuracy score. A position that is still training is never filtered, because a dropped request would produce no feedback for the predictor. The block also emits a one-cycle event for every dropped candidate and for every issued request, so that a separate profiling unit can keep its usefulness counters current. There is no input handshake: a candidate is always either accepted or reported as dropped.

Top module: `pf_conf_filter`

## Requirements
- R1: A candidate with `in_warm`=1 and `in_conf`=0 (Low) is never queued. It is reported on the drop port with cause 1 (confidence).
- R2: A candidate with `in_warm`=1 and `in_conf` equal to 1 (Medium), 2 (High) or 3 (treated as High) enters the urgent queue. It is later issued with `out_hi`=1.
- R3: A candidate with `in_warm`=0 enters the background queue whatever its confidence. It is never dropped for confidence and is issued with `out_hi`=0.
- R4: The downstream port presents the background queue's head only when the urgent queue is empty. An urgent arrival takes the port over from a waiting background head in the very next cycle.
- R5: Each queue holds DEPTH entries (default 8). A candidate whose target queue is full is dropped with cause 2 (full).
- R6: A candidate whose address equals that of an entry held in either queue is merged. It is not enqueued and is reported with cause 3 (merge). A confidence drop takes precedence over a merge, and a merge takes precedence over a full drop.
- R7: A handshake (`out_valid` and `out_ready` both high at a clock edge) produces, in the following cycle, a one-cycle `iss_valid` pulse. The pulse carries the issued address, region, position and queue flag. There is no pulse without a handshake.
- R8: A dropped candidate produces, in the cycle after it arrives, a one-cycle `drop_valid` pulse carrying its address, region, position and cause. An accepted candidate produces no drop pulse.
- R9: Within each queue, requests are issued in arrival order.
- R10: After reset both queues are empty, `out_valid` is 0, and neither event pulse is asserted.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high in the next cycle. No queued request is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate present this cycle |
| in_addr | input | AW | Candidate line address |
| in_region | input | RW | Candidate code-region identifier |
| in_pos | input | PW | Candidate stream position |
| in_conf | input | 2 | Predicted confidence (0 Low, 1 Medium, 2/3 High) |
| in_warm | input | 1 | Position has finished training |
| out_valid | output | 1 | A queued request is offered |
| out_ready | input | 1 | Downstream accepts the offered request |
| out_hi | output | 1 | Offered request comes from the urgent queue |
| out_addr | output | AW | Offered address |
| out_region | output | RW | Offered region identifier |
| out_pos | output | PW | Offered stream position |
| drop_valid | output | 1 | Drop event pulse |
| drop_cause | output | 2 | 1 confidence, 2 full, 3 merge |
| drop_addr | output | AW | Dropped address |
| drop_region | output | RW | Dropped region identifier |
| drop_pos | output | PW | Dropped stream position |
| iss_valid | output | 1 | Issue event pulse |
| iss_hi | output | 1 | Issued request came from the urgent queue |
| iss_addr | output | AW | Issued address |
| iss_region | output | RW | Issued region identifier |
| iss_pos | output | PW | Issued stream position |

## Verification
The properties assume that `in_conf` and `in_warm` are known whenever `in_valid` is high. They also assume that `out_ready` is a plain level that does not depend combinationally on anything other than `out_valid`. The stimulus drives every input at the falling edge and gives each candidate a fully defined confidence and warm flag. No test retires an address in the same cycle that an equal address arrives, so merge outcomes never hinge on that race. Queue contents are observed only through the downstream port and the two event ports.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;

    typedef enum logic [1:0] {
        CONF_LOW  = 2'd0,
        CONF_MED  = 2'd1,
        CONF_HIGH = 2'd2,
        CONF_TOP  = 2'd3
    } conf_e;

    typedef enum logic [1:0] {
        DROP_NONE  = 2'd0,
        DROP_CONF  = 2'd1,
        DROP_FULL  = 2'd2,
        DROP_MERGE = 2'd3
    } drop_e;

    typedef enum logic [1:0] {
        STEER_NONE = 2'd0,
        STEER_HI   = 2'd1,
        STEER_LO   = 2'd2,
        STEER_DROP = 2'd3
    } steer_e;

endpackage

// File: rtl/pf_queue.sv
module pf_queue #(
    parameter int AW    = 16,
    parameter int RW    = 8,
    parameter int PW    = 4,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [RW-1:0] push_region,
    input  logic [PW-1:0] push_pos,
    input  logic          pop,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic [AW-1:0] head_addr,
    output logic [RW-1:0] head_region,
    output logic [PW-1:0] head_pos,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = PTR_W + 1;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [RW-1:0] region;
        logic [PW-1:0] pos;
    } slot_t;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CW-1:0]    cnt;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    slot_t mem_d [DEPTH];
    slot_t mem_q [DEPTH];
    logic  push_ok, pop_ok;
    logic [DEPTH-1:0] slot_hit;

    assign empty   = (ctl_q.cnt == '0);
    assign full    = (ctl_q.cnt == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    assign head_addr   = mem_q[ctl_q.rd].addr;
    assign head_region = mem_q[ctl_q.rd].region;
    assign head_pos    = mem_q[ctl_q.rd].pos;

    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        logic [PTR_W-1:0] age;
        assign age         = PTR_W'(i) - ctl_q.rd;
        assign slot_hit[i] = (CW'(age) < ctl_q.cnt) && (mem_q[i].addr == probe_addr);
    end
    assign probe_hit = |slot_hit;

    always_comb begin
        ctl_d = ctl_q;
        for (int k = 0; k < DEPTH; k++) mem_d[k] = mem_q[k];
        if (push_ok) begin
            mem_d[ctl_q.wr] = '{addr: push_addr, region: push_region, pos: push_pos};
            ctl_d.wr        = ctl_q.wr + 1'b1;
        end
        if (pop_ok) ctl_d.rd = ctl_q.rd + 1'b1;
        ctl_d.cnt = ctl_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
        for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_d[k];
    end
endmodule

// File: rtl/pf_steer.sv
module pf_steer
    import pf_filter_pkg::*;
(
    input  logic        req,
    input  logic [1:0]  conf,
    input  logic        warm,
    input  logic        hi_full,
    input  logic        lo_full,
    input  logic        hi_hit,
    input  logic        lo_hit,
    output steer_e      steer,
    output drop_e       cause
);
    always_comb begin
        steer = STEER_NONE;
        cause = DROP_NONE;
        if (req) begin
            if (warm && conf == CONF_LOW) begin
                steer = STEER_DROP;
                cause = DROP_CONF;
            end else if (hi_hit || lo_hit) begin
                steer = STEER_DROP;
                cause = DROP_MERGE;
            end else if (warm) begin
                steer = hi_full ? STEER_DROP : STEER_HI;
                cause = hi_full ? DROP_FULL : DROP_NONE;
            end else begin
                steer = lo_full ? STEER_DROP : STEER_LO;
                cause = lo_full ? DROP_FULL : DROP_NONE;
            end
        end
    end
endmodule

// File: rtl/pf_pick.sv
module pf_pick (
    input  logic hi_empty,
    input  logic lo_empty,
    input  logic ready,
    output logic valid,
    output logic sel_hi,
    output logic pop_hi,
    output logic pop_lo
);
    assign sel_hi = !hi_empty;
    assign valid  = !hi_empty || !lo_empty;
    assign pop_hi = ready && !hi_empty;
    assign pop_lo = ready && hi_empty && !lo_empty;
endmodule

// File: rtl/pf_conf_filter.sv
module pf_conf_filter
    import pf_filter_pkg::*;
#(
    parameter int AW    = 16,
    parameter int RW    = 8,
    parameter int PW    = 4,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [RW-1:0] in_region,
    input  logic [PW-1:0] in_pos,
    input  logic [1:0]    in_conf,
    input  logic          in_warm,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_hi,
    output logic [AW-1:0] out_addr,
    output logic [RW-1:0] out_region,
    output logic [PW-1:0] out_pos,
    output logic          drop_valid,
    output logic [1:0]    drop_cause,
    output logic [AW-1:0] drop_addr,
    output logic [RW-1:0] drop_region,
    output logic [PW-1:0] drop_pos,
    output logic          iss_valid,
    output logic          iss_hi,
    output logic [AW-1:0] iss_addr,
    output logic [RW-1:0] iss_region,
    output logic [PW-1:0] iss_pos
);
    typedef struct packed {
        logic          drop_v;
        logic [1:0]    drop_c;
        logic [AW-1:0] drop_a;
        logic [RW-1:0] drop_r;
        logic [PW-1:0] drop_p;
        logic          iss_v;
        logic          iss_h;
        logic [AW-1:0] iss_a;
        logic [RW-1:0] iss_r;
        logic [PW-1:0] iss_p;
    } ev_t;

    ev_t ev_d, ev_q;

    logic          hi_empty, hi_full, hi_hit, pop_hi;
    logic          lo_empty, lo_full, lo_hit, pop_lo;
    logic [AW-1:0] hi_a, lo_a;
    logic [RW-1:0] hi_r, lo_r;
    logic [PW-1:0] hi_p, lo_p;
    steer_e        steer;
    drop_e         cause;
    logic          sel_hi;

    pf_steer i_steer (
        .req     (in_valid),
        .conf    (in_conf),
        .warm    (in_warm),
        .hi_full (hi_full),
        .lo_full (lo_full),
        .hi_hit  (hi_hit),
        .lo_hit  (lo_hit),
        .steer   (steer),
        .cause   (cause)
    );

    pf_queue #(.AW(AW), .RW(RW), .PW(PW), .DEPTH(DEPTH)) i_hi_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (steer == STEER_HI),
        .push_addr   (in_addr),
        .push_region (in_region),
        .push_pos    (in_pos),
        .pop         (pop_hi),
        .probe_addr  (in_addr),
        .probe_hit   (hi_hit),
        .head_addr   (hi_a),
        .head_region (hi_r),
        .head_pos    (hi_p),
        .empty       (hi_empty),
        .full        (hi_full)
    );

    pf_queue #(.AW(AW), .RW(RW), .PW(PW), .DEPTH(DEPTH)) i_lo_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (steer == STEER_LO),
        .push_addr   (in_addr),
        .push_region (in_region),
        .push_pos    (in_pos),
        .pop         (pop_lo),
        .probe_addr  (in_addr),
        .probe_hit   (lo_hit),
        .head_addr   (lo_a),
        .head_region (lo_r),
        .head_pos    (lo_p),
        .empty       (lo_empty),
        .full        (lo_full)
    );

    pf_pick i_pick (
        .hi_empty (hi_empty),
        .lo_empty (lo_empty),
        .ready    (out_ready),
        .valid    (out_valid),
        .sel_hi   (sel_hi),
        .pop_hi   (pop_hi),
        .pop_lo   (pop_lo)
    );

    assign out_hi     = sel_hi;
    assign out_addr   = sel_hi ? hi_a : lo_a;
    assign out_region = sel_hi ? hi_r : lo_r;
    assign out_pos    = sel_hi ? hi_p : lo_p;

    always_comb begin
        ev_d        = '0;
        ev_d.drop_v = (steer == STEER_DROP);
        ev_d.drop_c = cause;
        ev_d.drop_a = in_addr;
        ev_d.drop_r = in_region;
        ev_d.drop_p = in_pos;
        ev_d.iss_v  = out_valid && out_ready;
        ev_d.iss_h  = sel_hi;
        ev_d.iss_a  = out_addr;
        ev_d.iss_r  = out_region;
        ev_d.iss_p  = out_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign drop_valid  = ev_q.drop_v;
    assign drop_cause  = ev_q.drop_c;
    assign drop_addr   = ev_q.drop_a;
    assign drop_region = ev_q.drop_r;
    assign drop_pos    = ev_q.drop_p;
    assign iss_valid   = ev_q.iss_v;
    assign iss_hi      = ev_q.iss_h;
    assign iss_addr    = ev_q.iss_a;
    assign iss_region  = ev_q.iss_r;
    assign iss_pos     = ev_q.iss_p;
endmodule

// File: rtl/pf_conf_filter_chk.sv
module pf_conf_filter_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_conf,
    input logic          in_warm,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_hi,
    input logic [AW-1:0] out_addr,
    input logic          hi_empty,
    input logic          drop_valid,
    input logic [1:0]    drop_cause,
    input logic          iss_valid,
    input logic          iss_hi,
    input logic [AW-1:0] iss_addr
);
    AST_LOW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_warm && in_conf == 2'd0 |=> drop_valid && drop_cause == 2'd1); // R1
    AST_COLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_warm |=> !(drop_valid && drop_cause == 2'd1)); // R3
    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hi |-> hi_empty); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid); // R11
    AST_ISSUE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> iss_valid && iss_addr == $past(out_addr) && iss_hi == $past(out_hi)); // R7
    AST_ISSUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> !iss_valid); // R7
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !drop_valid); // R8
endmodule

bind pf_conf_filter pf_conf_filter_chk #(.AW(AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_conf    (in_conf),
    .in_warm    (in_warm),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_hi     (out_hi),
    .out_addr   (out_addr),
    .hi_empty   (hi_empty),
    .drop_valid (drop_valid),
    .drop_cause (drop_cause),
    .iss_valid  (iss_valid),
    .iss_hi     (iss_hi),
    .iss_addr   (iss_addr)
);

// File: tb/test_pf_conf_filter.sv
module test_pf_conf_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_addr;
    logic [7:0]  in_region;
    logic [3:0]  in_pos;
    logic [1:0]  in_conf;
    logic        in_warm;
    logic        out_valid, out_ready, out_hi;
    logic [15:0] out_addr;
    logic [7:0]  out_region;
    logic [3:0]  out_pos;
    logic        drop_valid;
    logic [1:0]  drop_cause;
    logic [15:0] drop_addr;
    logic [7:0]  drop_region;
    logic [3:0]  drop_pos;
    logic        iss_valid, iss_hi;
    logic [15:0] iss_addr;
    logic [7:0]  iss_region;
    logic [3:0]  iss_pos;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_a [16];
    logic        exp_h [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_conf_filter i_pf_conf_filter (.*);

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  r;
        logic [3:0]  p;
        logic [1:0]  c;
        logic        w;
        logic [1:0]  cause;
    } vec_t;

    localparam vec_t VT [10] = '{
        '{16'h0100, 8'd1, 4'd1, 2'd2, 1'b1, 2'd0},
        '{16'h0200, 8'd1, 4'd2, 2'd0, 1'b1, 2'd1},
        '{16'h0300, 8'd2, 4'd1, 2'd0, 1'b0, 2'd0},
        '{16'h0400, 8'd2, 4'd2, 2'd1, 1'b1, 2'd0},
        '{16'h0100, 8'd3, 4'd3, 2'd1, 1'b1, 2'd3},
        '{16'h0300, 8'd3, 4'd1, 2'd2, 1'b1, 2'd3},
        '{16'h0500, 8'd4, 4'd1, 2'd2, 1'b0, 2'd0},
        '{16'h0600, 8'd4, 4'd2, 2'd0, 1'b1, 2'd1},
        '{16'h0700, 8'd5, 4'd1, 2'd3, 1'b1, 2'd0},
        '{16'h0400, 8'd6, 4'd1, 2'd0, 1'b1, 2'd1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] a, input logic [7:0] r, input logic [3:0] p,
                        input logic [1:0] c, input logic w, input logic [1:0] cause);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_region = r; in_pos = p; in_conf = c; in_warm = w;
        @(negedge clk);
        in_valid = 1'b0;
        if (cause == 2'd0)
            check(!drop_valid, "R8 no drop pulse for accepted request", {31'd0, drop_valid}, 32'd0);
        else
            check(drop_valid && drop_cause == cause && drop_addr == a && drop_region == r && drop_pos == p,
                  (cause == 2'd1) ? "R1 confidence drop" : (cause == 2'd2) ? "R5 full drop" : "R6 merge drop",
                  {drop_valid, 13'd0, drop_cause, drop_addr}, {1'b1, 13'd0, cause, a});
    endtask

    task automatic drain(input int n);
        @(negedge clk);
        out_ready = 1'b1;
        for (int k = 0; k < n; k++) begin
            check(out_valid && out_addr == exp_a[k] && out_hi == exp_h[k], "R9 R4 issue order/queue",
                  {out_valid, out_hi, 14'd0, out_addr}, {1'b1, exp_h[k], 14'd0, exp_a[k]});
            @(negedge clk);
            check(iss_valid && iss_addr == exp_a[k] && iss_hi == exp_h[k], "R7 issue pulse",
                  {iss_valid, iss_hi, 14'd0, iss_addr}, {1'b1, exp_h[k], 14'd0, exp_a[k]});
        end
        out_ready = 1'b0;
        check(!out_valid, "R9 queues empty after drain", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check(!iss_valid, "R7 no pulse without handshake", {31'd0, iss_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_region = '0; in_pos = '0;
        in_conf = '0; in_warm = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!out_valid && !drop_valid && !iss_valid, "R10 reset state",
              {29'd0, out_valid, drop_valid, iss_valid}, 32'd0);

        // Table walk: R1 R2 R3 R6 R8
        for (int i = 0; i < 10; i++)
            send(VT[i].a, VT[i].r, VT[i].p, VT[i].c, VT[i].w, VT[i].cause);

        exp_a[0] = 16'h0100; exp_h[0] = 1'b1;   // R2
        exp_a[1] = 16'h0400; exp_h[1] = 1'b1;
        exp_a[2] = 16'h0700; exp_h[2] = 1'b1;
        exp_a[3] = 16'h0300; exp_h[3] = 1'b0;   // R3
        exp_a[4] = 16'h0500; exp_h[4] = 1'b0;
        drain(5);

        // R5 full urgent queue, background still accepts
        for (int i = 0; i < 8; i++) begin
            send(16'h1000 + 16'(i), 8'd7, 4'(i), 2'd2, 1'b1, 2'd0);
            exp_a[i] = 16'h1000 + 16'(i); exp_h[i] = 1'b1;
        end
        send(16'h2000, 8'd7, 4'd9, 2'd1, 1'b1, 2'd2);
        send(16'h2100, 8'd7, 4'd9, 2'd0, 1'b0, 2'd0);
        exp_a[8] = 16'h2100; exp_h[8] = 1'b0;
        drain(9);

        // R4 urgent arrival preempts a waiting background head; R11 stall hold
        send(16'h3000, 8'd8, 4'd1, 2'd2, 1'b0, 2'd0);
        check(out_valid && !out_hi && out_addr == 16'h3000, "R11 background head offered",
              {out_valid, out_hi, 14'd0, out_addr}, {2'b10, 14'd0, 16'h3000});
        @(negedge clk);
        check(out_valid && out_addr == 16'h3000, "R11 head held under stall",
              {out_valid, 15'd0, out_addr}, {1'b1, 15'd0, 16'h3000});
        @(negedge clk);
        in_valid = 1'b1; in_addr = 16'h3100; in_region = 8'd8; in_pos = 4'd2; in_conf = 2'd1; in_warm = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_hi && out_addr == 16'h3100, "R4 urgent takes over port",
              {out_valid, out_hi, 14'd0, out_addr}, {2'b11, 14'd0, 16'h3100});
        exp_a[0] = 16'h3100; exp_h[0] = 1'b1;
        exp_a[1] = 16'h3000; exp_h[1] = 1'b0;
        drain(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule